// File: doc/BRIEF.md
# Two-Word-Aware Decode and Execute Slice

This block is a compact execution slice for an 8-bit register machine with thirty-two 8-bit general registers and 16-bit instruction words. It accepts instruction words on a valid/ready fetch port and recognises three operations:

- **register add**, which writes the sum back into the first operand;
- **compare against an 8-bit constant**, which changes only the status flags;
- **direct load** from data memory.

The direct load spans two fetch words. After the first word the slice keeps the fetch port ready for one more word, which it treats as a full 16-bit data address. It then closes the port while it performs a synchronous data-memory read and writes the returned byte into the destination register.

The slice owns the register file and five status flags. Each register write is announced on a write-back port, one cycle after the cause that produced it. Any first word that matches none of the three patterns gives a one-cycle illegal pulse and leaves every register and flag untouched.

Top module: `exec_slice`

## Requirements
- R1: An active-high synchronous reset clears all 32 registers and all flags, drops `wb_valid`, `illegal` and `dmem_rd_en`, and leaves `fetch_ready` high in the first-word state.
- R2: A word of the form `000011 s ddddd ssss` is a register add. The destination is bits 8..4, and the source is bit 9 (high) joined with bits 3..0. On acceptance, Rd receives the 8-bit sum Rd+Rs. In the next cycle `wb_valid` is 1 with `wb_idx`=d and `wb_data`=sum. Example: 0x0E0F adds R31 into R0.
- R3: After an add, `flags` holds {H,V,N,Z,C} in bits 4..0:
  - C is the carry out of bit 7;
  - H is the carry out of bit 3;
  - N is bit 7 of the result;
  - Z is set when the result is zero;
  - V is two's-complement overflow.
- R4: A word whose top nibble is 0011 is a compare. Its constant is bits 11..8 (high nibble) joined with bits 3..0 (low nibble). Its register is 16 plus bits 7..4. It updates only the flags, and `wb_valid` stays 0. Example: 0x3F0F compares R16 with 255.
- R5: After a compare, `flags` reflects register minus constant:
  - C is set when the constant is unsigned-greater than the register;
  - H is set when the constant's low nibble exceeds the register's low nibble;
  - V is two's-complement overflow of the subtraction;
  - N and Z come from the 8-bit difference.
- R6: A first word matching `1001000 ddddd 0000` is a direct load. `fetch_ready` stays 1 so that one more word can be accepted, and no memory read happens yet. The cycle after that second word is accepted, `dmem_rd_en` is 1 for exactly one cycle and `dmem_addr` equals the second word.
- R7: Data memory returns the byte on `dmem_rd_data` in the cycle after `dmem_rd_en`. One cycle after that read cycle, `wb_valid` is 1 with `wb_idx`=d and `wb_data`=that byte, and Rd holds it. `fetch_ready` is 0 from the cycle after the address word is accepted until `wb_valid` is shown. A load leaves the flags unchanged.
- R8: An accepted first word matching none of the three patterns gives `illegal`=1 for one cycle, with `wb_valid`=0 and `flags` unchanged. No register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction word present |
| fetch_word | input | 16 | Instruction or address word |
| fetch_ready | output | 1 | Slice accepts a word this cycle |
| dmem_rd_en | output | 1 | Data-memory read strobe |
| dmem_addr | output | 16 | Data-memory read address |
| dmem_rd_data | input | 8 | Byte returned one cycle after the strobe |
| wb_valid | output | 1 | A register was written |
| wb_idx | output | 5 | Index of the written register |
| wb_data | output | 8 | Value written |
| flags | output | 5 | Status {H,V,N,Z,C} |
| illegal | output | 1 | One-cycle unknown-instruction pulse |

## Verification
The bench builds the slice with its default parameters: 32 registers, 8-bit data and 16-bit words and addresses. With these values every register index can be reached by the split add fields and by the load destination, and the whole upper half of the file can be reached by the compare. The bench fills all 32 registers through direct loads from addresses whose returned byte it chooses. This lets it place exact operand pairs that exercise carry, half-carry, overflow and zero results on both add and compare. It also runs loads back to back with adds and inserts idle gaps on the fetch port.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {ST_DEC, ST_ADDR, ST_REQ, ST_LOAD} seq_state_t;
  typedef enum logic [1:0] {OP_BAD, OP_ADD, OP_CMP, OP_LDS} op_kind_t;
  typedef struct packed {
    logic h;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/slice_decoder.sv
module slice_decoder
  import slice_pkg::*;
#(
  parameter int IW     = 16,
  parameter int DW     = 8,
  parameter int RIDX_W = 5
) (
  input  logic [IW-1:0]     word,
  output op_kind_t          kind,
  output logic [RIDX_W-1:0] dst_idx,
  output logic [RIDX_W-1:0] src_idx,
  output logic [DW-1:0]     imm
);
  // Field positions are fixed by the instruction encoding.
  logic is_add, is_cmp, is_lds;

  always_comb begin
    is_add = (word[15:10] == 6'b000011);
    is_cmp = (word[15:12] == 4'b0011);
    is_lds = (word[15:9] == 7'b1001000) && (word[3:0] == 4'b0000);

    kind = OP_BAD;
    if (is_add)      kind = OP_ADD;
    else if (is_cmp) kind = OP_CMP;
    else if (is_lds) kind = OP_LDS;

    // Split fields: the source high bit sits apart; compare reaches the upper half only.
    src_idx = {word[9], word[3:0]};
    imm     = {word[11:8], word[3:0]};
    if (is_cmp) dst_idx = {1'b1, word[7:4]};
    else        dst_idx = word[8:4];
  end
endmodule

// File: rtl/slice_regfile.sv
module slice_regfile #(
  parameter int NREG   = 32,
  parameter int DW     = 8,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [RIDX_W-1:0] rb_idx,
  output logic [DW-1:0]     ra_data,
  output logic [DW-1:0]     rb_data
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output flags_t        flg
);
  localparam int HB = DW / 2;
  logic [DW:0] full;
  logic [HB:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b};
      half = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]};
    end else begin
      full = {1'b0, a} + {1'b0, b};
      half = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]};
    end
    res   = full[DW-1:0];
    flg.c = full[DW];
    flg.h = half[HB];
    flg.n = full[DW-1];
    flg.z = (full[DW-1:0] == '0);
    if (sub) flg.v = (a[DW-1] != b[DW-1]) && (full[DW-1] != a[DW-1]);
    else     flg.v = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/exec_slice.sv
module exec_slice
  import slice_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int IW   = 16,
  parameter int AW   = 16,
  localparam int RIDX_W = $clog2(NREG),
  localparam int FW     = $bits(flags_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [IW-1:0]     fetch_word,
  output logic              fetch_ready,
  output logic              dmem_rd_en,
  output logic [AW-1:0]     dmem_addr,
  input  logic [DW-1:0]     dmem_rd_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [DW-1:0]     wb_data,
  output logic [FW-1:0]     flags,
  output logic              illegal
);
  seq_state_t        state;
  op_kind_t          kind;
  logic [RIDX_W-1:0] dst_idx, src_idx, lds_idx;
  logic [DW-1:0]     imm, ra, rb, alu_b, alu_res;
  flags_t            alu_flg, flags_q;
  logic              accept, dec_fire, rf_we;
  logic [RIDX_W-1:0] rf_waddr;
  logic [DW-1:0]     rf_wdata;

  slice_decoder #(.IW(IW), .DW(DW), .RIDX_W(RIDX_W)) u_dec (
    .word(fetch_word), .kind(kind), .dst_idx(dst_idx),
    .src_idx(src_idx), .imm(imm)
  );

  slice_regfile #(.NREG(NREG), .DW(DW), .RIDX_W(RIDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_idx(dst_idx), .rb_idx(src_idx), .ra_data(ra), .rb_data(rb)
  );

  slice_alu #(.DW(DW)) u_alu (
    .a(ra), .b(alu_b), .sub(kind == OP_CMP), .res(alu_res), .flg(alu_flg)
  );

  assign fetch_ready = (state == ST_DEC) || (state == ST_ADDR);
  assign accept      = fetch_valid && fetch_ready;
  assign dec_fire    = accept && (state == ST_DEC);
  assign alu_b       = (kind == OP_CMP) ? imm : rb;
  assign flags       = flags_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dst_idx;
    rf_wdata = alu_res;
    if (state == ST_LOAD) begin
      rf_we    = 1'b1;
      rf_waddr = lds_idx;
      rf_wdata = dmem_rd_data;
    end else if (dec_fire && kind == OP_ADD) begin
      rf_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_DEC;
      lds_idx    <= '0;
      flags_q    <= '0;
      wb_valid   <= 1'b0;
      wb_idx     <= '0;
      wb_data    <= '0;
      illegal    <= 1'b0;
      dmem_rd_en <= 1'b0;
      dmem_addr  <= '0;
    end else begin
      wb_valid   <= 1'b0;
      illegal    <= 1'b0;
      dmem_rd_en <= 1'b0;
      unique case (state)
        ST_DEC: if (accept) begin
          unique case (kind)
            OP_ADD: begin
              flags_q  <= alu_flg;
              wb_valid <= 1'b1;
              wb_idx   <= dst_idx;
              wb_data  <= alu_res;
            end
            OP_CMP: flags_q <= alu_flg;
            OP_LDS: begin
              lds_idx <= dst_idx;
              state   <= ST_ADDR;
            end
            default: illegal <= 1'b1;
          endcase
        end
        ST_ADDR: if (accept) begin
          dmem_rd_en <= 1'b1;
          dmem_addr  <= fetch_word[AW-1:0];
          state      <= ST_REQ;
        end
        ST_REQ: state <= ST_LOAD;
        ST_LOAD: begin
          wb_valid <= 1'b1;
          wb_idx   <= lds_idx;
          wb_data  <= dmem_rd_data;
          state    <= ST_DEC;
        end
        default: state <= ST_DEC;
      endcase
    end
  end

  // R2: an accepted add reports its destination in the next cycle
  p_add_wb_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && kind == OP_ADD) |=> (wb_valid && wb_idx == $past(dst_idx)));
  // R4: a compare never writes a register
  p_cmp_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && kind == OP_CMP) |=> !wb_valid);
  // R6: the read strobe lasts one cycle
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    dmem_rd_en |=> !dmem_rd_en);
  // R7: fetch is closed while a read is in flight
  p_ready_off_r7: assert property (@(posedge clk) disable iff (rst)
    dmem_rd_en |-> !fetch_ready);
  // R7: write-back follows the read cycle by one
  p_load_wb_r7: assert property (@(posedge clk) disable iff (rst)
    dmem_rd_en |=> ##1 wb_valid);
  // R8: an illegal word writes nothing and keeps the flags
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wb_valid && $stable(flags)));
endmodule

// File: tb/test_exec_slice.sv
module test_exec_slice;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_word = '0;
  logic        fetch_ready, dmem_rd_en, wb_valid, illegal;
  logic [15:0] dmem_addr;
  logic [7:0]  dmem_rd_data = '0;
  logic [4:0]  wb_idx, flags;
  logic [7:0]  wb_data;

  exec_slice i_exec_slice (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .fetch_ready(fetch_ready), .dmem_rd_en(dmem_rd_en), .dmem_addr(dmem_addr),
    .dmem_rd_data(dmem_rd_data), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .flags(flags), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Data memory model: byte = low address byte XOR high address byte.
  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction
  always @(posedge clk) if (dmem_rd_en) dmem_rd_data <= memf(dmem_addr);

  typedef struct {
    bit         is_ill;
    logic [4:0] idx;
    logic [7:0] data;
    logic [4:0] flg;
  } ev_t;
  ev_t q[$];

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] mreg [32];
  logic [4:0] mflags = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every write-back or illegal pulse must match the queue head.
  always @(negedge clk) begin
    if (!rst && (wb_valid || illegal)) begin
      if (q.size() == 0) begin
        chk(0, "R2", "unexpected event", {wb_valid, illegal}, 0);
      end else begin
        ev_t e;
        e = q.pop_front();
        if (e.is_ill) begin
          chk(illegal && !wb_valid, "R8", "illegal pulse", {wb_valid, illegal}, 1);
          chk(flags == e.flg, "R8", "flags kept", flags, e.flg);
        end else begin
          chk(wb_valid && !illegal, "R2", "wb event", {wb_valid, illegal}, 2);
          chk(wb_idx == e.idx, "R2", "wb_idx", wb_idx, e.idx);
          chk(wb_data == e.data, "R7", "wb_data", wb_data, e.data);
          chk(flags == e.flg, "R3", "flags", flags, e.flg);
        end
      end
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1'b1;
    fetch_word  = w;
    @(negedge clk);
    fetch_valid = 1'b0;
    fetch_word  = 16'h0000;
  endtask

  function automatic logic [4:0] add_flags(input logic [7:0] a, input logic [7:0] b);
    int s, ss;
    logic [4:0] f;
    s  = int'(a) + int'(b);
    ss = int'($signed(a)) + int'($signed(b));
    f[0] = (s > 255);
    f[1] = (s % 256) == 0;
    f[2] = ((s % 256) >= 128);
    f[3] = (ss > 127) || (ss < -128);
    f[4] = (int'(a[3:0]) + int'(b[3:0])) > 15;
    return f;
  endfunction

  function automatic logic [4:0] sub_flags(input logic [7:0] a, input logic [7:0] k);
    int ds;
    logic [7:0] d;
    logic [4:0] f;
    d  = a - k;
    ds = int'($signed(a)) - int'($signed(k));
    f[0] = (k > a);
    f[1] = (d == 0);
    f[2] = d[7];
    f[3] = (ds > 127) || (ds < -128);
    f[4] = (k[3:0] > a[3:0]);
    return f;
  endfunction

  task automatic do_add(input int d, input int r);
    ev_t e;
    logic [7:0] s;
    logic [4:0] dd, rr;
    dd = d[4:0];
    rr = r[4:0];
    s = mreg[d] + mreg[r];
    mflags = add_flags(mreg[d], mreg[r]);
    mreg[d] = s;
    e.is_ill = 0; e.idx = dd; e.data = s; e.flg = mflags;
    q.push_back(e);
    send({6'b000011, rr[4], dd, rr[3:0]});   // R2 encoding
  endtask

  task automatic do_cmp(input int di, input logic [7:0] k);
    logic [3:0] f;
    f = di[3:0];
    mflags = sub_flags(mreg[16 + di], k);
    send({4'b0011, k[7:4], f, k[3:0]});
    chk(flags == mflags, "R5", "compare flags", flags, mflags);
    chk(!wb_valid, "R4", "compare writes nothing", wb_valid, 0);
  endtask

  task automatic do_lds(input int d, input logic [15:0] a);
    ev_t e;
    logic [4:0] dd;
    dd = d[4:0];
    mreg[d] = memf(a);
    e.is_ill = 0; e.idx = dd; e.data = mreg[d]; e.flg = mflags;
    q.push_back(e);
    send({7'b1001000, dd, 4'b0000});
    chk(fetch_ready && !dmem_rd_en, "R6", "awaits address word",
        {fetch_ready, dmem_rd_en}, 2);
    send(a);
    chk(dmem_rd_en, "R6", "read strobe", dmem_rd_en, 1);
    chk(dmem_addr == a, "R6", "read address", dmem_addr, a);
    chk(!fetch_ready, "R7", "fetch held off", fetch_ready, 0);
    @(negedge clk);
    chk(!dmem_rd_en && !fetch_ready, "R7", "strobe drop, still held",
        {dmem_rd_en, fetch_ready}, 0);
    @(negedge clk);
    chk(fetch_ready, "R7", "fetch reopened with write-back", fetch_ready, 1);
  endtask

  task automatic do_ill(input logic [15:0] w);
    ev_t e;
    e.is_ill = 1; e.idx = '0; e.data = '0; e.flg = mflags;
    q.push_back(e);
    send(w);
    @(negedge clk);
    chk(!illegal, "R8", "pulse is one cycle", illegal, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(fetch_ready, "R1", "ready after reset", fetch_ready, 1);
    chk(!wb_valid && !illegal && !dmem_rd_en, "R1", "outputs idle",
        {wb_valid, illegal, dmem_rd_en}, 0);
    chk(flags == 5'b0, "R1", "flags cleared", flags, 0);
    do_add(5, 9);   // R1: registers cleared, sum 0 with Z

    // R6/R7: fill every register through direct loads
    for (int i = 0; i < 32; i++) do_lds(i, 16'h0137 * i[15:0] + 16'h0011);
    do_lds(12, 16'h3115);

    // R2/R3 add patterns including the R31 -> R0 case
    do_add(0, 31);
    for (int i = 0; i < 24; i++) do_add((i * 7) % 32, (i * 13 + 5) % 32);
    do_lds(1, 16'h0080); do_lds(2, 16'h0080); do_add(1, 2);   // carry, overflow, zero
    do_lds(3, 16'h000F); do_lds(4, 16'h0001); do_add(3, 4);   // half carry
    do_lds(5, 16'h007F); do_lds(6, 16'h0001); do_add(5, 6);   // overflow to negative
    do_add(7, 7);

    // R4/R5 compares
    do_lds(16, 16'h0010);
    do_cmp(0, 8'hFF);                          // constant above register: C
    do_cmp(0, 8'h10);                          // equal: Z
    do_lds(31, 16'h0080); do_cmp(15, 8'h01);   // signed overflow
    do_lds(20, 16'h0023); do_cmp(4, 8'h05);    // half borrow
    do_cmp(9, 8'h00);

    // R8 illegal words, with gaps on the fetch port
    do_ill(16'h0000);
    repeat (3) @(negedge clk);
    do_ill(16'hFFFF);
    do_ill(16'h9001);
    do_ill(16'h0800);
    do_ill(16'h9200);
    do_add(16, 20);   // registers still intact after illegal words

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2", "all expected events seen", q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule